// File: doc/BRIEF.md
# Invalidation Acknowledgement Collector

This block sits between a processor and the coherence network on the requesting side. The processor issues a write miss or a writeback and expects exactly one completion for it. The network answers a write with several separate messages: one reply from the home that carries a count of invalidations still in flight, plus one acknowledgement per invalidated sharer, sent straight to the requester. The block holds one entry per outstanding transaction. It keeps a signed balance of acknowledgements per entry and reports one completion to the processor only when the whole transaction has finished.

Interventions from other requesters can arrive for a line that still has a transaction open here. If the open transaction is a write, the intervention is parked in that entry and handed to the cache one cycle after the write's completion is reported. If the open transaction is a writeback, the intervention is dropped, because the writeback already carries the data to the home. Interventions for any other line pass straight through.

Top module: `inv_ack_collector`

## Requirements
- R1: After reset no completion, forward or drop output is valid, `req_ready` and `itv_ready` are high and `req_tag` is 0.
- R2: A request is accepted when `req_valid` and `req_ready` are both high. It takes the lowest-numbered free entry, and `req_tag` shows that index in the cycle it is accepted. Up to NUM_ENT (default 4) transactions are open at once.
- R3: A write completes (`done_valid`=1, `done_retry`=0, `done_tag` = its entry) in the cycle after the clock edge at which its reply has arrived and its balance has reached zero. A reply alone does not complete a write while acknowledgements are still owed.
- R4: Acknowledgements (`ack_valid`, `ack_tag`) may arrive before the reply. The balance goes negative, and the reply's count brings it back to zero.
- R5: `rep_kind` encoding: 0 = exclusive or upgrade grant with `rep_cnt` pending acknowledgements, 1 = NACK, 2 = writeback acknowledgement. A NACK closes the entry with `done_retry`=1 and frees it.
- R6: A writeback entry completes with `done_retry`=0 when a writeback acknowledgement (kind 2) arrives for it.
- R7: While every entry is in use, `req_ready` is low. It rises again once an entry's completion has been reported.
- R8: An intervention for a line that has an open write is held. It is not forwarded or dropped when it arrives. It appears on `fwd_*` with `fwd_held`=1 in the cycle after that write's `done_valid`.
- R9: An intervention for a line that has an open writeback is discarded. `drop_valid` pulses in the next cycle with its source, and nothing is forwarded.
- R10: An intervention for a line with no open transaction is forwarded in the next cycle with `fwd_held`=0.
- R11: `itv_ready` is low while a held intervention is waiting to be released, and also while the offered line matches a write that already holds one or a transaction whose completion is being reported. At most one held intervention is released per cycle.
- R12: A reply and an acknowledgement for the same entry on the same edge are both counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor offers a new transaction |
| req_ready | output | 1 | A free entry exists |
| req_wb | input | 1 | 1 = writeback, 0 = write (exclusive or upgrade) |
| req_line | input | LINE_W | Line address of the request |
| req_tag | output | TAG_W | Entry index given to the offered request |
| rep_valid | input | 1 | Home reply valid |
| rep_tag | input | TAG_W | Entry the reply belongs to |
| rep_kind | input | 2 | 0 grant, 1 NACK, 2 writeback ack |
| rep_cnt | input | CNT_W-1 | Acknowledgements to expect (grant only) |
| ack_valid | input | 1 | Invalidation acknowledgement valid |
| ack_tag | input | TAG_W | Entry the acknowledgement belongs to |
| itv_valid | input | 1 | Intervention offered |
| itv_ready | output | 1 | Intervention can be taken this cycle |
| itv_line | input | LINE_W | Intervention line address |
| itv_src | input | SRC_W | Intervention source identifier |
| done_valid | output | 1 | One transaction finished |
| done_tag | output | TAG_W | Entry that finished |
| done_retry | output | 1 | Finished by NACK; processor must retry |
| fwd_valid | output | 1 | Intervention passed to the cache |
| fwd_line | output | LINE_W | Line of forwarded intervention |
| fwd_src | output | SRC_W | Source of forwarded intervention |
| fwd_held | output | 1 | Forwarded intervention had been held |
| drop_valid | output | 1 | Intervention discarded |
| drop_src | output | SRC_W | Source of discarded intervention |

## Verification
The grant reply and an invalidation acknowledgement for the same entry can land on the same clock edge. The balance must then take the count and the decrement together. The bench provokes this from its vector table by driving `rep_valid` and `ack_valid` together for one entry, with other acknowledgements placed before and after. It judges the result by requiring `done_valid` to stay low after every event except the last, and to rise exactly one cycle after the last one. A second overlap is a held release meeting a fresh intervention. The bench checks that `itv_ready` is low in the cycle the release is pending.

// File: rtl/ackc_pkg.sv
package ackc_pkg;

  typedef enum logic [1:0] {
    ES_FREE = 2'd0,
    ES_WAIT = 2'd1,
    ES_DONE = 2'd2,
    ES_REL  = 2'd3
  } ent_state_e;

  typedef enum logic [1:0] {
    RK_GRANT = 2'd0,
    RK_NACK  = 2'd1,
    RK_WBACK = 2'd2
  } rep_kind_e;

endpackage

// File: rtl/ackc_pick.sv
module ackc_pick #(
  parameter int N     = 4,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  logic found;

  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        idx_o    = IDX_W'(i);
        found    = 1'b1;
      end
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/ackc_entry.sv
module ackc_entry
  import ackc_pkg::*;
#(
  parameter int LINE_W = 16,
  parameter int SRC_W  = 4,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic              alloc_wb_i,
  input  logic [LINE_W-1:0] alloc_line_i,
  input  logic              rep_hit_i,
  input  logic [1:0]        rep_kind_i,
  input  logic [CNT_W-2:0]  rep_cnt_i,
  input  logic              ack_hit_i,
  input  logic              hold_i,
  input  logic [SRC_W-1:0]  hold_src_i,
  input  logic              report_i,
  input  logic              release_i,
  output ent_state_e        state_o,
  output logic              wb_o,
  output logic [LINE_W-1:0] line_o,
  output logic              held_o,
  output logic [SRC_W-1:0]  held_src_o,
  output logic              retry_o,
  output logic              close_ok_o,
  output logic              bal_zero_o
);
  localparam logic signed [CNT_W-1:0] BAL_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // Balance arithmetic: add the granted count, take one per acknowledgement.
  function automatic logic signed [CNT_W-1:0] next_balance(
    input logic signed [CNT_W-1:0] cur,
    input logic                    add_en,
    input logic [CNT_W-2:0]        add,
    input logic                    dec_en
  );
    logic signed [CNT_W-1:0] r;
    r = cur;
    if (add_en) r = r + $signed({1'b0, add});
    if (dec_en) r = r - BAL_ONE;
    return r;
  endfunction

  ent_state_e              state_q;
  logic                    wb_q;
  logic [LINE_W-1:0]       line_q;
  logic                    got_q;
  logic signed [CNT_W-1:0] bal_q;
  logic                    held_q;
  logic [SRC_W-1:0]        hsrc_q;
  logic                    retry_q;

  logic                    in_wait;
  logic                    reply_ok;
  logic                    nack_hit;
  logic                    add_en;
  logic                    dec_en;
  logic                    got_n;
  logic signed [CNT_W-1:0] bal_n;
  logic                    close_nack;
  logic                    close_ok;

  always_comb begin
    in_wait    = (state_q == ES_WAIT);
    nack_hit   = rep_hit_i && (rep_kind_i == RK_NACK);
    reply_ok   = rep_hit_i && (wb_q ? (rep_kind_i == RK_WBACK)
                                    : (rep_kind_i == RK_GRANT));
    add_en     = rep_hit_i && !wb_q && (rep_kind_i == RK_GRANT);
    dec_en     = ack_hit_i && !wb_q;
    bal_n      = next_balance(bal_q, add_en, rep_cnt_i, dec_en);
    got_n      = got_q || reply_ok;
    close_nack = in_wait && nack_hit;
    close_ok   = in_wait && !nack_hit && got_n && (bal_n == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ES_FREE;
      wb_q    <= 1'b0;
      line_q  <= '0;
      got_q   <= 1'b0;
      bal_q   <= '0;
      held_q  <= 1'b0;
      hsrc_q  <= '0;
      retry_q <= 1'b0;
    end else begin
      unique case (state_q)
        ES_FREE: begin
          if (alloc_i) begin
            state_q <= ES_WAIT;
            wb_q    <= alloc_wb_i;
            line_q  <= alloc_line_i;
            got_q   <= 1'b0;
            bal_q   <= '0;
            held_q  <= 1'b0;
            retry_q <= 1'b0;
          end
        end
        ES_WAIT: begin
          bal_q <= bal_n;
          got_q <= got_n;
          if (hold_i) begin
            held_q <= 1'b1;
            hsrc_q <= hold_src_i;
          end
          if (close_nack) begin
            state_q <= ES_DONE;
            retry_q <= 1'b1;
          end else if (close_ok) begin
            state_q <= ES_DONE;
          end
        end
        ES_DONE: begin
          if (report_i) state_q <= (held_q || hold_i) ? ES_REL : ES_FREE;
        end
        ES_REL: begin
          if (release_i) begin
            state_q <= ES_FREE;
            held_q  <= 1'b0;
          end
        end
        default: state_q <= ES_FREE;
      endcase
    end
  end

  assign state_o    = state_q;
  assign wb_o       = wb_q;
  assign line_o     = line_q;
  assign held_o     = held_q;
  assign held_src_o = hsrc_q;
  assign retry_o    = retry_q;
  assign close_ok_o = close_ok;
  assign bal_zero_o = (bal_q == '0);
endmodule

// File: rtl/inv_ack_collector.sv
module inv_ack_collector
  import ackc_pkg::*;
#(
  parameter int NUM_ENT = 4,
  parameter int LINE_W  = 16,
  parameter int SRC_W   = 4,
  parameter int CNT_W   = 6,
  parameter int TAG_W   = $clog2(NUM_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wb,
  input  logic [LINE_W-1:0] req_line,
  output logic [TAG_W-1:0]  req_tag,
  input  logic              rep_valid,
  input  logic [TAG_W-1:0]  rep_tag,
  input  logic [1:0]        rep_kind,
  input  logic [CNT_W-2:0]  rep_cnt,
  input  logic              ack_valid,
  input  logic [TAG_W-1:0]  ack_tag,
  input  logic              itv_valid,
  output logic              itv_ready,
  input  logic [LINE_W-1:0] itv_line,
  input  logic [SRC_W-1:0]  itv_src,
  output logic              done_valid,
  output logic [TAG_W-1:0]  done_tag,
  output logic              done_retry,
  output logic              fwd_valid,
  output logic [LINE_W-1:0] fwd_line,
  output logic [SRC_W-1:0]  fwd_src,
  output logic              fwd_held,
  output logic              drop_valid,
  output logic [SRC_W-1:0]  drop_src
);
  ent_state_e                     ent_state [NUM_ENT];
  logic [NUM_ENT-1:0]             ent_wb;
  logic [NUM_ENT-1:0][LINE_W-1:0] ent_line;
  logic [NUM_ENT-1:0]             ent_held;
  logic [NUM_ENT-1:0][SRC_W-1:0]  ent_hsrc;
  logic [NUM_ENT-1:0]             ent_retry;

  // Named internal events, observed by the bound checker.
  logic [NUM_ENT-1:0] ent_busy;
  logic [NUM_ENT-1:0] ent_close_ok;
  logic [NUM_ENT-1:0] ent_bal_zero;
  logic               rel_pend;

  logic [NUM_ENT-1:0] free_vec, done_vec, rel_vec, match_vec;
  logic [NUM_ENT-1:0] alloc_gnt, done_gnt, rel_gnt, match_gnt;
  logic [TAG_W-1:0]   alloc_idx, done_idx, rel_idx, match_idx;
  logic               alloc_any, done_any, rel_any, match_any;

  logic req_acc, itv_acc;
  logic hold_case, drop_case, pass_case;

  always_comb begin
    for (int i = 0; i < NUM_ENT; i++) begin
      free_vec[i]  = (ent_state[i] == ES_FREE);
      done_vec[i]  = (ent_state[i] == ES_DONE);
      rel_vec[i]   = (ent_state[i] == ES_REL);
      ent_busy[i]  = !free_vec[i];
      match_vec[i] = ent_busy[i] && (ent_line[i] == itv_line);
    end
  end

  ackc_pick #(.N(NUM_ENT), .IDX_W(TAG_W)) u_alloc_pick (
    .req_i(free_vec), .gnt_o(alloc_gnt), .idx_o(alloc_idx), .any_o(alloc_any));
  ackc_pick #(.N(NUM_ENT), .IDX_W(TAG_W)) u_done_pick (
    .req_i(done_vec), .gnt_o(done_gnt), .idx_o(done_idx), .any_o(done_any));
  ackc_pick #(.N(NUM_ENT), .IDX_W(TAG_W)) u_rel_pick (
    .req_i(rel_vec), .gnt_o(rel_gnt), .idx_o(rel_idx), .any_o(rel_any));
  ackc_pick #(.N(NUM_ENT), .IDX_W(TAG_W)) u_match_pick (
    .req_i(match_vec), .gnt_o(match_gnt), .idx_o(match_idx), .any_o(match_any));

  assign req_ready = alloc_any;
  assign req_tag   = alloc_idx;
  assign req_acc   = req_valid && req_ready;
  assign rel_pend  = rel_any;

  // Intervention classification against the matching entry.
  always_comb begin
    pass_case = !match_any;
    hold_case = match_any && (ent_state[match_idx] == ES_WAIT)
                && !ent_wb[match_idx] && !ent_held[match_idx];
    drop_case = match_any && (ent_state[match_idx] == ES_WAIT)
                && ent_wb[match_idx];
    itv_ready = !rel_any && (pass_case || hold_case || drop_case);
    itv_acc   = itv_valid && itv_ready;
  end

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(g);
    ackc_entry #(.LINE_W(LINE_W), .SRC_W(SRC_W), .CNT_W(CNT_W)) u_ent (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_i      (req_acc && alloc_gnt[g]),
      .alloc_wb_i   (req_wb),
      .alloc_line_i (req_line),
      .rep_hit_i    (rep_valid && (rep_tag == MY_TAG)),
      .rep_kind_i   (rep_kind),
      .rep_cnt_i    (rep_cnt),
      .ack_hit_i    (ack_valid && (ack_tag == MY_TAG)),
      .hold_i       (itv_acc && hold_case && match_gnt[g]),
      .hold_src_i   (itv_src),
      .report_i     (done_gnt[g]),
      .release_i    (rel_gnt[g]),
      .state_o      (ent_state[g]),
      .wb_o         (ent_wb[g]),
      .line_o       (ent_line[g]),
      .held_o       (ent_held[g]),
      .held_src_o   (ent_hsrc[g]),
      .retry_o      (ent_retry[g]),
      .close_ok_o   (ent_close_ok[g]),
      .bal_zero_o   (ent_bal_zero[g])
    );
  end

  // Completion reporting: one finished entry per cycle, lowest index first.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_valid <= 1'b0;
      done_tag   <= '0;
      done_retry <= 1'b0;
    end else begin
      done_valid <= done_any;
      done_tag   <= done_idx;
      done_retry <= done_any && ent_retry[done_idx];
    end
  end

  // Intervention output: a held release takes the slot, else a pass-through.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid  <= 1'b0;
      fwd_line   <= '0;
      fwd_src    <= '0;
      fwd_held   <= 1'b0;
      drop_valid <= 1'b0;
      drop_src   <= '0;
    end else begin
      drop_valid <= itv_acc && drop_case;
      drop_src   <= itv_src;
      if (rel_any) begin
        fwd_valid <= 1'b1;
        fwd_line  <= ent_line[rel_idx];
        fwd_src   <= ent_hsrc[rel_idx];
        fwd_held  <= 1'b1;
      end else begin
        fwd_valid <= itv_acc && pass_case;
        fwd_line  <= itv_line;
        fwd_src   <= itv_src;
        fwd_held  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ackc_checker.sv
module ackc_checker #(
  parameter int NUM_ENT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               itv_ready,
  input logic               done_valid,
  input logic               fwd_valid,
  input logic               fwd_held,
  input logic               drop_valid,
  input logic               rel_pend,
  input logic [NUM_ENT-1:0] ent_busy,
  input logic [NUM_ENT-1:0] ent_close_ok,
  input logic [NUM_ENT-1:0] ent_bal_zero
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!done_valid && !fwd_valid && !drop_valid && req_ready))
    else $error("assert_reset_quiet_R1");

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_bal
    assert_close_balanced_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ent_close_ok[i] |=> ent_bal_zero[i])
      else $error("assert_close_balanced_R3 entry %0d", i);
  end

  assert_full_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(ent_busy) == NUM_ENT) |-> !req_ready)
    else $error("assert_full_stall_R7");

  assert_release_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && fwd_held) |-> $past(done_valid))
    else $error("assert_release_after_done_R8");

  assert_drop_not_fwd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drop_valid |-> !fwd_valid)
    else $error("assert_drop_not_fwd_R9");

  assert_release_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rel_pend |-> !itv_ready)
    else $error("assert_release_blocks_R11");
endmodule

bind inv_ack_collector ackc_checker #(.NUM_ENT(NUM_ENT)) u_ackc_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .itv_ready    (itv_ready),
  .done_valid   (done_valid),
  .fwd_valid    (fwd_valid),
  .fwd_held     (fwd_held),
  .drop_valid   (drop_valid),
  .rel_pend     (rel_pend),
  .ent_busy     (ent_busy),
  .ent_close_ok (ent_close_ok),
  .ent_bal_zero (ent_bal_zero)
);

// File: tb/inv_ack_collector_tb_top.sv
module inv_ack_collector_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_ENT = 4;
  localparam int LINE_W  = 16;
  localparam int SRC_W   = 4;
  localparam int CNT_W   = 6;
  localparam int TAG_W   = 2;

  // Each vector: {count, acks before reply, ack with reply, acks after}
  localparam int NVEC = 6;
  localparam logic [15:0] VEC [NVEC] = '{
    16'h0_0_0_0, 16'h3_0_0_3, 16'h2_2_0_0,
    16'h4_1_1_2, 16'h1_0_1_0, 16'h5_3_0_2
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_wb = 0;
  logic [LINE_W-1:0] req_line = '0;
  logic req_ready;
  logic [TAG_W-1:0] req_tag;
  logic rep_valid = 0;
  logic [TAG_W-1:0] rep_tag = '0;
  logic [1:0] rep_kind = '0;
  logic [CNT_W-2:0] rep_cnt = '0;
  logic ack_valid = 0;
  logic [TAG_W-1:0] ack_tag = '0;
  logic itv_valid = 0;
  logic itv_ready;
  logic [LINE_W-1:0] itv_line = '0;
  logic [SRC_W-1:0] itv_src = '0;
  logic done_valid, done_retry, fwd_valid, fwd_held, drop_valid;
  logic [TAG_W-1:0] done_tag;
  logic [LINE_W-1:0] fwd_line;
  logic [SRC_W-1:0] fwd_src, drop_src;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  inv_ack_collector #(.NUM_ENT(NUM_ENT), .LINE_W(LINE_W), .SRC_W(SRC_W),
                      .CNT_W(CNT_W), .TAG_W(TAG_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_wb(req_wb),
    .req_line(req_line), .req_tag(req_tag),
    .rep_valid(rep_valid), .rep_tag(rep_tag), .rep_kind(rep_kind), .rep_cnt(rep_cnt),
    .ack_valid(ack_valid), .ack_tag(ack_tag),
    .itv_valid(itv_valid), .itv_ready(itv_ready), .itv_line(itv_line), .itv_src(itv_src),
    .done_valid(done_valid), .done_tag(done_tag), .done_retry(done_retry),
    .fwd_valid(fwd_valid), .fwd_line(fwd_line), .fwd_src(fwd_src), .fwd_held(fwd_held),
    .drop_valid(drop_valid), .drop_src(drop_src)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_req(input logic wb, input logic [LINE_W-1:0] line, input int exp_tag);
    req_valid = 1; req_wb = wb; req_line = line;
    chk(req_ready === 1'b1, "R2 ready", int'(req_ready), 1);
    chk(req_tag == TAG_W'(exp_tag), "R2 tag", int'(req_tag), exp_tag);
    cyc();
    req_valid = 0;
  endtask

  task automatic send_ack(input int tag);
    ack_valid = 1; ack_tag = TAG_W'(tag);
    cyc();
    ack_valid = 0;
  endtask

  task automatic send_rep(input int tag, input logic [1:0] kind, input int cnt);
    rep_valid = 1; rep_tag = TAG_W'(tag); rep_kind = kind; rep_cnt = (CNT_W-1)'(cnt);
    cyc();
    rep_valid = 0;
  endtask

  task automatic send_itv(input logic [LINE_W-1:0] line, input int src);
    itv_valid = 1; itv_line = line; itv_src = SRC_W'(src);
    chk(itv_ready === 1'b1, "R11 itv_ready for takeable intervention", int'(itv_ready), 1);
    cyc();
    itv_valid = 0;
  endtask

  task automatic expect_done(input string req, input int tag, input int retry);
    chk(done_valid === 1'b1, req, int'(done_valid), 1);
    chk(done_tag == TAG_W'(tag) && done_retry == retry[0], req,
        int'(done_tag) * 2 + int'(done_retry), tag * 2 + retry);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(req_ready === 1'b1 && itv_ready === 1'b1, "R1 ready after reset",
        int'(req_ready) + int'(itv_ready), 2);
    chk(req_tag == '0, "R1 tag after reset", int'(req_tag), 0);
    chk(!done_valid && !fwd_valid && !drop_valid, "R1 outputs quiet",
        int'(done_valid) + int'(fwd_valid) + int'(drop_valid), 0);

    // Vector table: write transactions with varied acknowledgement ordering (R3 R4 R12)
    for (int v = 0; v < NVEC; v++) begin
      int cnt, early, same, late;
      cnt   = int'(VEC[v][15:12]);
      early = int'(VEC[v][11:8]);
      same  = int'(VEC[v][7:4]);
      late  = int'(VEC[v][3:0]);
      send_req(1'b0, LINE_W'(16'h0020 + v), 0);
      for (int k = 0; k < early; k++) begin
        send_ack(0);
        chk(done_valid === 1'b0, "R4 no completion on early ack", int'(done_valid), 0);
      end
      rep_valid = 1; rep_tag = '0; rep_kind = 2'd0; rep_cnt = (CNT_W-1)'(cnt);
      ack_valid = (same != 0); ack_tag = '0;
      cyc();
      rep_valid = 0; ack_valid = 0;
      chk(done_valid === 1'b0, "R12 completion not before next cycle", int'(done_valid), 0);
      for (int k = 0; k < late; k++) begin
        chk(done_valid === 1'b0, "R3 no completion with acks owed", int'(done_valid), 0);
        send_ack(0);
      end
      cyc();
      expect_done("R3 write completes after final event", 0, 0);
    end

    // Fill all entries (R2 R7)
    for (int t = 0; t < NUM_ENT; t++) send_req(1'b0, LINE_W'(16'h0010 + t), t);
    chk(req_ready === 1'b0, "R7 stall when full", int'(req_ready), 0);

    // NACK frees entry 2 (R5)
    send_rep(2, 2'd1, 0);
    chk(done_valid === 1'b0, "R5 nack report timing", int'(done_valid), 0);
    cyc();
    expect_done("R5 nack retry", 2, 1);
    chk(req_ready === 1'b1, "R7 ready after free", int'(req_ready), 1);
    chk(req_tag == 2'd2, "R2 lowest free tag", int'(req_tag), 2);

    // Writeback in entry 2
    send_req(1'b1, 16'h0040, 2);

    // Intervention for writeback line is dropped (R9)
    send_itv(16'h0040, 5);
    chk(drop_valid === 1'b1 && drop_src == 4'd5, "R9 drop",
        int'(drop_valid) * 16 + int'(drop_src), 16 + 5);
    chk(fwd_valid === 1'b0, "R9 no forward", int'(fwd_valid), 0);

    // Unrelated line passes through (R10)
    send_itv(16'h0099, 6);
    chk(fwd_valid === 1'b1 && fwd_held === 1'b0 && fwd_line == 16'h0099 && fwd_src == 4'd6,
        "R10 pass through", int'(fwd_line), 16'h0099);

    // Intervention for open write in entry 1 is held (R8)
    send_itv(16'h0011, 7);
    chk(!fwd_valid && !drop_valid, "R8 held not forwarded",
        int'(fwd_valid) + int'(drop_valid), 0);

    // Second intervention to same line refused (R11)
    itv_valid = 1; itv_line = 16'h0011; itv_src = 4'd8;
    #1;
    chk(itv_ready === 1'b0, "R11 refuse second hold", int'(itv_ready), 0);
    itv_valid = 0;

    // Close entry 1, then released held intervention (R8 R11)
    send_rep(1, 2'd0, 0);
    chk(done_valid === 1'b0, "R3 report one cycle later", int'(done_valid), 0);
    cyc();
    expect_done("R8 write completion before release", 1, 0);
    chk(itv_ready === 1'b0, "R11 release pending blocks", int'(itv_ready), 0);
    chk(fwd_valid === 1'b0, "R8 no release with completion", int'(fwd_valid), 0);
    cyc();
    chk(fwd_valid === 1'b1 && fwd_held === 1'b1, "R8 release held",
        int'(fwd_valid) * 2 + int'(fwd_held), 3);
    chk(fwd_line == 16'h0011 && fwd_src == 4'd7, "R8 release content",
        int'(fwd_src), 7);
    chk(itv_ready === 1'b1, "R11 ready after release", int'(itv_ready), 1);

    // Writeback acknowledgement (R6)
    send_rep(2, 2'd2, 0);
    cyc();
    expect_done("R6 writeback completes", 2, 0);

    // Ack ahead of reply on entry 0 (R4)
    send_ack(0);
    send_rep(0, 2'd0, 1);
    cyc();
    expect_done("R4 early ack then reply", 0, 0);

    send_rep(3, 2'd0, 0);
    cyc();
    expect_done("R3 last entry", 3, 0);

    cyc();
    chk(req_ready === 1'b1 && req_tag == '0, "R2 all free again", int'(req_tag), 0);

    summary();
    $finish;
  end
endmodule